// File: doc/BRIEF.md
# Debug Command Frame Decoder

This block sits between the word-level transport of a debug port and the unit that carries out debug commands. It takes a stream of 16-bit words over a valid/ready handshake. It treats the first word of each frame as the operation word and splits that word into a command code, a transfer direction, an operand size, an address-or-data register select and a register number. From these fields it works out how many extension words the frame still needs.

The decoder then gathers the extension words. A memory address is always 32 bits long and comes as two words. Write data is one word for byte and word operands and two words for longword operands. When the last word is accepted, the block emits a single-cycle command strobe. With it come the decoded fields, an address aligned to the operand size and data placed in the low bits of a 32-bit output. An operation word that is not well formed produces a one-cycle error strobe, and its frame is dropped. A synchronous abort discards any partly built frame.

Two code masks, given as parameters, say which command codes carry an address and which carry write data. By default, data follows only when the direction bit says host to target.

Top module: `cmdfrm_decoder`

## Requirements
- R1: When `cmd_valid` is high, `cmd_code` equals operation-word bits 15..10. `cmd_to_host` equals bit 8 (1 = target to host). `cmd_size` equals bits 7..6, where 00 = byte, 01 = word and 10 = longword. `cmd_areg` equals bit 3 (1 = address register). `cmd_regnum` equals bits 2..0.
- R2: An operation word with bit 9, bit 5 or bit 4 set raises `cmd_err` for one cycle in the cycle after it is accepted. It gives no `cmd_valid`, and the next word is taken as a new operation word.
- R3: An operation word with size field 11 is handled as an error in the same way as R2.
- R4: Codes selected by `ADDR_CODE_MASK` (default: code 1) take two address words. Codes selected by `DATA_CODE_MASK` (default: codes 1 and 2) with bit 8 = 0 then take data words: one for byte or word size, two for longword size. Address words come first, and each multi-word value arrives most-significant word first. `cmd_valid` rises in the cycle after the last word of the frame is accepted, and never earlier.
- R5: `cmd_addr` has bits 1..0 cleared for longword size and bit 0 cleared for word size. For byte size it is passed through unchanged. It is zero for commands without an address.
- R6: For byte size, `cmd_data` holds the low 8 bits of the data word, zero-extended. For word size it holds the data word, zero-extended. For longword size it holds {first word, second word}. It is zero when the frame has no data.
- R7: While `abort` is high, no word is accepted and `in_ready` is low. The frame in progress is dropped, no strobe follows, and the next accepted word starts a new frame.
- R8: `cmd_valid` and `cmd_err` are each one cycle per frame and are never high together.
- R9: Outside abort, `in_ready` is high. Cycles with `in_valid` low between the words of a frame leave the frame undisturbed.
- R10: After reset, `cmd_valid`, `cmd_err`, `cmd_addr` and `cmd_data` are 0, `in_ready` is 1, and the next word is taken as an operation word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| abort | input | 1 | Discard partial frame, return to idle |
| in_valid | input | 1 | Word on `in_word` is valid |
| in_word | input | WORD_W | Incoming command word |
| in_ready | output | 1 | Block accepts a word this cycle |
| cmd_valid | output | 1 | One-cycle strobe: decoded command present |
| cmd_err | output | 1 | One-cycle strobe: malformed operation word |
| cmd_code | output | 6 | Command code |
| cmd_to_host | output | 1 | Transfer direction, 1 = target to host |
| cmd_size | output | 2 | Operand size code |
| cmd_areg | output | 1 | 1 = address register, 0 = data register |
| cmd_regnum | output | 3 | Register number |
| cmd_addr | output | ADDR_W | Size-aligned address |
| cmd_data | output | DATA_W | Right-justified immediate data |

## Verification
The bench aims at frame lengths that depend on the decoded fields. A decoder that miscounts would strobe early, or it would swallow the next operation word as data; reads, register writes and code-0 frames each cover a different length. Odd addresses with every size expose wrong alignment. A byte operand with a non-zero upper byte shows a missing right-justification. Each reserved bit and the reserved size are driven on their own, and a good frame follows them to show that the error path does not leave stale state. An abort with a word waiting is followed by a one-word frame. A design that still took words would treat that word as an address and stay silent. Idle gaps inside a frame and back-to-back one-word frames test the handshake.

// File: rtl/dbgcmd_pkg.sv
package dbgcmd_pkg;

   localparam int OPW_W  = 16;
   localparam int CODE_W = 6;
   localparam int REG_W  = 3;

   typedef enum logic [1:0] {
      SZ_BYTE = 2'b00,
      SZ_WORD = 2'b01,
      SZ_LONG = 2'b10,
      SZ_RSVD = 2'b11
   } opsize_e;

   typedef enum logic [1:0] {
      ST_IDLE,
      ST_ADDR_HI,
      ST_ADDR_LO,
      ST_DATA
   } frame_st_e;

   typedef struct packed {
      logic [CODE_W-1:0] code;
      logic              to_host;
      opsize_e           size;
      logic              areg;
      logic [REG_W-1:0]  regnum;
   } opfields_t;

endpackage

// File: rtl/cmdfrm_opword_decode.sv
module cmdfrm_opword_decode
   import dbgcmd_pkg::*;
#(
   parameter logic [63:0] ADDR_CODE_MASK     = 64'h2,
   parameter logic [63:0] DATA_CODE_MASK     = 64'h6,
   parameter bit          DATA_ON_WRITE_ONLY = 1'b1
) (
   input  logic [OPW_W-1:0] opword,
   output opfields_t        fields,
   output logic             malformed,
   output logic             needs_addr,
   output logic             needs_data,
   output logic             data_two
);

   localparam int N_CODES = 2 ** CODE_W;

   if (N_CODES > 64) begin : g_bad_codes
      $error("command code space exceeds mask width");
   end

   logic resv_set;
   logic size_bad;
   logic data_code;

   always_comb begin
      fields.code    = opword[15:10];
      fields.to_host = opword[8];
      fields.size    = opsize_e'(opword[7:6]);
      fields.areg    = opword[3];
      fields.regnum  = opword[2:0];
   end

   assign resv_set  = opword[9] | opword[5] | opword[4];
   assign size_bad  = (opword[7:6] == SZ_RSVD);
   assign malformed = resv_set | size_bad;

   assign needs_addr = ADDR_CODE_MASK[opword[15:10]];
   assign data_code  = DATA_CODE_MASK[opword[15:10]];
   assign data_two   = (opword[7:6] == SZ_LONG);

   if (DATA_ON_WRITE_ONLY) begin : g_data_write
      assign needs_data = data_code & ~opword[8];
   end else begin : g_data_always
      assign needs_data = data_code;
   end

endmodule

// File: rtl/cmdfrm_addr_align.sv
module cmdfrm_addr_align
   import dbgcmd_pkg::*;
#(
   parameter int ADDR_W = 32
) (
   input  logic [ADDR_W-1:0] raw_addr,
   input  opsize_e           size,
   output logic [ADDR_W-1:0] aligned_addr
);

   if (ADDR_W < 2) begin : g_bad_addr
      $error("address too narrow for alignment");
   end

   always_comb begin
      aligned_addr = raw_addr;
      case (size)
         SZ_WORD: aligned_addr[0]   = 1'b0;
         SZ_LONG: aligned_addr[1:0] = 2'b00;
         default: ;
      endcase
   end

endmodule

// File: rtl/cmdfrm_data_pack.sv
module cmdfrm_data_pack
   import dbgcmd_pkg::*;
#(
   parameter int WORD_W = 16,
   parameter int DATA_W = 32
) (
   input  logic [WORD_W-1:0] hi_word,
   input  logic [WORD_W-1:0] lo_word,
   input  opsize_e           size,
   output logic [DATA_W-1:0] data
);

   localparam int BYTE_W = 8;

   if (DATA_W != 2 * WORD_W) begin : g_bad_data
      $error("data width must hold two words");
   end

   always_comb begin
      data = '0;
      case (size)
         SZ_BYTE: data[BYTE_W-1:0] = lo_word[BYTE_W-1:0];
         SZ_WORD: data[WORD_W-1:0] = lo_word;
         SZ_LONG: data = {hi_word, lo_word};
         default: data = '0;
      endcase
   end

endmodule

// File: rtl/cmdfrm_decoder.sv
module cmdfrm_decoder
   import dbgcmd_pkg::*;
#(
   parameter int          WORD_W             = 16,
   parameter int          ADDR_W             = 32,
   parameter int          DATA_W             = 32,
   parameter logic [63:0] ADDR_CODE_MASK     = 64'h2,
   parameter logic [63:0] DATA_CODE_MASK     = 64'h6,
   parameter bit          DATA_ON_WRITE_ONLY = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              abort,
   input  logic              in_valid,
   input  logic [WORD_W-1:0] in_word,
   output logic              in_ready,
   output logic              cmd_valid,
   output logic              cmd_err,
   output logic [5:0]        cmd_code,
   output logic              cmd_to_host,
   output logic [1:0]        cmd_size,
   output logic              cmd_areg,
   output logic [2:0]        cmd_regnum,
   output logic [ADDR_W-1:0] cmd_addr,
   output logic [DATA_W-1:0] cmd_data
);

   if (WORD_W != OPW_W) begin : g_bad_word
      $error("word width must match operation word width");
   end
   if (ADDR_W != 2 * WORD_W) begin : g_bad_addr
      $error("address must span exactly two words");
   end

   frame_st_e         state_q;
   opfields_t         fld_q;
   logic              need_data_q;
   logic              data_two_q;
   logic              data_second_q;
   logic [WORD_W-1:0] addr_hi_q, addr_lo_q;
   logic [WORD_W-1:0] dat_hi_q, dat_lo_q;
   logic              valid_q, err_q;

   opfields_t dec_fields;
   logic      dec_bad, dec_addr, dec_data, dec_two;
   logic      take;

   cmdfrm_opword_decode #(
      .ADDR_CODE_MASK    (ADDR_CODE_MASK),
      .DATA_CODE_MASK    (DATA_CODE_MASK),
      .DATA_ON_WRITE_ONLY(DATA_ON_WRITE_ONLY)
   ) u_dec (
      .opword    (in_word),
      .fields    (dec_fields),
      .malformed (dec_bad),
      .needs_addr(dec_addr),
      .needs_data(dec_data),
      .data_two  (dec_two)
   );

   assign in_ready = ~abort;
   assign take     = in_valid & in_ready;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q       <= ST_IDLE;
         fld_q         <= '0;
         need_data_q   <= 1'b0;
         data_two_q    <= 1'b0;
         data_second_q <= 1'b0;
         addr_hi_q     <= '0;
         addr_lo_q     <= '0;
         dat_hi_q      <= '0;
         dat_lo_q      <= '0;
         valid_q       <= 1'b0;
         err_q         <= 1'b0;
      end else begin
         valid_q <= 1'b0;
         err_q   <= 1'b0;
         if (abort) begin
            state_q <= ST_IDLE;
         end else if (take) begin
            case (state_q)
               ST_IDLE: begin
                  if (dec_bad) begin
                     err_q <= 1'b1;
                  end else begin
                     fld_q         <= dec_fields;
                     need_data_q   <= dec_data;
                     data_two_q    <= dec_two;
                     data_second_q <= 1'b0;
                     addr_hi_q     <= '0;
                     addr_lo_q     <= '0;
                     dat_hi_q      <= '0;
                     dat_lo_q      <= '0;
                     if (dec_addr)      state_q <= ST_ADDR_HI;
                     else if (dec_data) state_q <= ST_DATA;
                     else               valid_q <= 1'b1;
                  end
               end
               ST_ADDR_HI: begin
                  addr_hi_q <= in_word;
                  state_q   <= ST_ADDR_LO;
               end
               ST_ADDR_LO: begin
                  addr_lo_q <= in_word;
                  if (need_data_q) begin
                     state_q <= ST_DATA;
                  end else begin
                     state_q <= ST_IDLE;
                     valid_q <= 1'b1;
                  end
               end
               ST_DATA: begin
                  if (data_two_q && !data_second_q) begin
                     dat_hi_q      <= in_word;
                     data_second_q <= 1'b1;
                  end else begin
                     dat_lo_q <= in_word;
                     state_q  <= ST_IDLE;
                     valid_q  <= 1'b1;
                  end
               end
               default: state_q <= ST_IDLE;
            endcase
         end
      end
   end

   cmdfrm_addr_align #(.ADDR_W(ADDR_W)) u_align (
      .raw_addr    ({addr_hi_q, addr_lo_q}),
      .size        (fld_q.size),
      .aligned_addr(cmd_addr)
   );

   cmdfrm_data_pack #(.WORD_W(WORD_W), .DATA_W(DATA_W)) u_pack (
      .hi_word(dat_hi_q),
      .lo_word(dat_lo_q),
      .size   (fld_q.size),
      .data   (cmd_data)
   );

   assign cmd_valid   = valid_q;
   assign cmd_err     = err_q;
   assign cmd_code    = fld_q.code;
   assign cmd_to_host = fld_q.to_host;
   assign cmd_size    = fld_q.size;
   assign cmd_areg    = fld_q.areg;
   assign cmd_regnum  = fld_q.regnum;

endmodule

// File: rtl/cmdfrm_decoder_chk.sv
module cmdfrm_decoder_chk #(
   parameter int DATA_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              abort,
   input logic              in_valid,
   input logic              in_ready,
   input logic              cmd_valid,
   input logic              cmd_err,
   input logic [1:0]        cmd_size,
   input logic [1:0]        addr_lo,
   input logic [DATA_W-9:0] data_up
);

   p_valid_after_take_r4: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid |-> $past(in_valid && in_ready));

   p_err_after_take_r2: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_err |-> $past(in_valid && in_ready));

   p_strobe_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !(cmd_valid && cmd_err));

   p_abort_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
      abort |=> !cmd_valid && !cmd_err);

   p_size_legal_r3: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid |-> cmd_size != 2'b11);

   p_long_align_r5: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid && cmd_size == 2'b10 |-> addr_lo == 2'b00);

   p_word_align_r5: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid && cmd_size == 2'b01 |-> addr_lo[0] == 1'b0);

   p_byte_zext_r6: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid && cmd_size == 2'b00 |-> data_up == '0);

   p_word_zext_r6: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid && cmd_size == 2'b01 |-> data_up[DATA_W-9:8] == '0);

endmodule

bind cmdfrm_decoder cmdfrm_decoder_chk #(.DATA_W(DATA_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .abort    (abort),
   .in_valid (in_valid),
   .in_ready (in_ready),
   .cmd_valid(cmd_valid),
   .cmd_err  (cmd_err),
   .cmd_size (cmd_size),
   .addr_lo  (cmd_addr[1:0]),
   .data_up  (cmd_data[DATA_W-1:8])
);

// File: tb/cmdfrm_decoder_tb.sv
module cmdfrm_decoder_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        abort = 1'b0;
   logic        in_valid = 1'b0;
   logic [15:0] in_word = '0;
   logic        in_ready, cmd_valid, cmd_err, cmd_to_host, cmd_areg;
   logic [5:0]  cmd_code;
   logic [1:0]  cmd_size;
   logic [2:0]  cmd_regnum;
   logic [31:0] cmd_addr, cmd_data;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   cmdfrm_decoder u_dut (
      .clk(clk), .rst_n(rst_n), .abort(abort), .in_valid(in_valid),
      .in_word(in_word), .in_ready(in_ready), .cmd_valid(cmd_valid),
      .cmd_err(cmd_err), .cmd_code(cmd_code), .cmd_to_host(cmd_to_host),
      .cmd_size(cmd_size), .cmd_areg(cmd_areg), .cmd_regnum(cmd_regnum),
      .cmd_addr(cmd_addr), .cmd_data(cmd_data)
   );

   typedef struct packed {
      logic [2:0]  nw;
      logic [15:0] w0, w1, w2, w3, w4;
      logic        ev, ee;
      logic [31:0] ea, ed;
   } vec_t;

   localparam int NV = 14;
   localparam vec_t VECS [NV] = '{
      '{3'd4, 16'h0400, 16'h1234, 16'h5677, 16'hABCD, 16'h0000, 1'b1, 1'b0, 32'h12345677, 32'h000000CD},
      '{3'd4, 16'h0440, 16'h8000, 16'h0003, 16'hBEEF, 16'h0000, 1'b1, 1'b0, 32'h80000002, 32'h0000BEEF},
      '{3'd5, 16'h0480, 16'hDEAD, 16'hBEEF, 16'h1122, 16'h3344, 1'b1, 1'b0, 32'hDEADBEEC, 32'h11223344},
      '{3'd3, 16'h0580, 16'h0000, 16'h0007, 16'h0000, 16'h0000, 1'b1, 1'b0, 32'h00000004, 32'h00000000},
      '{3'd3, 16'h088D, 16'hCAFE, 16'hF00D, 16'h0000, 16'h0000, 1'b1, 1'b0, 32'h00000000, 32'hCAFEF00D},
      '{3'd2, 16'h0843, 16'h5A5A, 16'h0000, 16'h0000, 16'h0000, 1'b1, 1'b0, 32'h00000000, 32'h00005A5A},
      '{3'd1, 16'h098F, 16'h0000, 16'h0000, 16'h0000, 16'h0000, 1'b1, 1'b0, 32'h00000000, 32'h00000000},
      '{3'd1, 16'h0000, 16'h0000, 16'h0000, 16'h0000, 16'h0000, 1'b1, 1'b0, 32'h00000000, 32'h00000000},
      '{3'd1, 16'h0600, 16'h0000, 16'h0000, 16'h0000, 16'h0000, 1'b0, 1'b1, 32'h00000000, 32'h00000000},
      '{3'd1, 16'h0420, 16'h0000, 16'h0000, 16'h0000, 16'h0000, 1'b0, 1'b1, 32'h00000000, 32'h00000000},
      '{3'd1, 16'h0410, 16'h0000, 16'h0000, 16'h0000, 16'h0000, 1'b0, 1'b1, 32'h00000000, 32'h00000000},
      '{3'd1, 16'h04C0, 16'h0000, 16'h0000, 16'h0000, 16'h0000, 1'b0, 1'b1, 32'h00000000, 32'h00000000},
      '{3'd3, 16'h0500, 16'hFFFF, 16'hFFFF, 16'h0000, 16'h0000, 1'b1, 1'b0, 32'hFFFFFFFF, 32'h00000000},
      '{3'd2, 16'h0801, 16'h77F1, 16'h0000, 16'h0000, 16'h0000, 1'b1, 1'b0, 32'h00000000, 32'h000000F1}
   };

   function automatic logic [15:0] wsel(input vec_t v, input int i);
      case (i)
         0: return v.w0;
         1: return v.w1;
         2: return v.w2;
         3: return v.w3;
         default: return v.w4;
      endcase
   endfunction

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic send(input logic [15:0] w);
      @(negedge clk);
      in_valid = 1'b1;
      in_word  = w;
      @(negedge clk);
      in_valid = 1'b0;
      in_word  = '0;
   endtask

   function automatic logic [31:0] fields_of(input logic [15:0] w);
      return {19'd0, w[15:10], w[8], w[7:6], w[3], w[2:0]};
   endfunction

   function automatic logic [31:0] fields_out();
      return {19'd0, cmd_code, cmd_to_host, cmd_size, cmd_areg, cmd_regnum};
   endfunction

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R10 reset state
      chk("R10 valid", {31'd0, cmd_valid}, 32'd0);
      chk("R10 err", {31'd0, cmd_err}, 32'd0);
      chk("R10 ready", {31'd0, in_ready}, 32'd1);
      chk("R10 addr", cmd_addr, 32'd0);
      chk("R10 data", cmd_data, 32'd0);

      // table walk: R1 R2 R3 R4 R5 R6 R8
      for (int k = 0; k < NV; k++) begin
         vec_t v;
         bit   early;
         v = VECS[k];
         early = 1'b0;
         for (int i = 0; i < int'(v.nw); i++) begin
            @(negedge clk);
            if (i > 0 && (cmd_valid || cmd_err)) early = 1'b1;
            in_valid = 1'b1;
            in_word  = wsel(v, i);
         end
         @(negedge clk);
         in_valid = 1'b0;
         in_word  = '0;
         chk("R4 no early strobe", {31'd0, early}, 32'd0);
         chk(k == 11 ? "R3 reserved size err" : "R2 err strobe", {31'd0, cmd_err}, {31'd0, v.ee});
         chk("R4 valid strobe", {31'd0, cmd_valid}, {31'd0, v.ev});
         if (v.ev) begin
            chk("R5 aligned addr", cmd_addr, v.ea);
            chk("R6 data", cmd_data, v.ed);
            chk("R1 fields", fields_out(), fields_of(v.w0));
         end
         @(negedge clk);
         chk("R8 single cycle", {30'd0, cmd_valid, cmd_err}, 32'd0);
      end

      // R9 gaps inside a frame
      begin
         bit seen;
         seen = 1'b0;
         @(negedge clk); in_valid = 1'b1; in_word = 16'h0480;
         @(negedge clk); in_valid = 1'b0;
         @(negedge clk); in_valid = 1'b1; in_word = 16'h0001;
         @(negedge clk); in_valid = 1'b0; seen |= cmd_valid;
         @(negedge clk); seen |= cmd_valid; in_valid = 1'b1; in_word = 16'h0006;
         @(negedge clk); in_valid = 1'b0; seen |= cmd_valid;
         @(negedge clk); in_valid = 1'b1; in_word = 16'h0000;
         @(negedge clk); in_valid = 1'b0; seen |= cmd_valid;
         @(negedge clk); seen |= cmd_valid; in_valid = 1'b1; in_word = 16'h0001;
         @(negedge clk); in_valid = 1'b0; in_word = '0;
         chk("R9 no strobe during gaps", {31'd0, seen}, 32'd0);
         chk("R9 valid after gaps", {31'd0, cmd_valid}, 32'd1);
         chk("R9 addr after gaps", cmd_addr, 32'h00010004);
         chk("R9 data after gaps", cmd_data, 32'h00000001);
      end

      // R7 abort mid-frame
      @(negedge clk); in_valid = 1'b1; in_word = 16'h0480;
      @(negedge clk); in_word = 16'h1111;
      @(negedge clk); abort = 1'b1; in_word = 16'h2222;
      #1;
      chk("R7 ready low in abort", {31'd0, in_ready}, 32'd0);
      @(negedge clk);
      abort = 1'b0; in_valid = 1'b0;
      chk("R7 no strobe after abort", {30'd0, cmd_valid, cmd_err}, 32'd0);
      send(16'h098F);
      chk("R7 new frame after abort", {31'd0, cmd_valid}, 32'd1);
      chk("R7 fields after abort", fields_out(), fields_of(16'h098F));

      // R4 back-to-back one-word frames
      @(negedge clk); in_valid = 1'b1; in_word = 16'h0000;
      @(negedge clk); in_word = 16'h0987;
      chk("R4 first back-to-back", {31'd0, cmd_valid}, 32'd1);
      chk("R1 first back-to-back code", fields_out(), fields_of(16'h0000));
      @(negedge clk); in_valid = 1'b0; in_word = '0;
      chk("R4 second back-to-back", {31'd0, cmd_valid}, 32'd1);
      chk("R1 second back-to-back code", fields_out(), fields_of(16'h0987));
      @(negedge clk);

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule